// File: doc/BRIEF.md
# AUX Request Sequencer

This block executes one decoded display-link AUX request at a time. A request carries a command code, an address, a byte count of 0 to 16, and up to 16 write bytes. Native requests become a run of single-byte accesses on a 1 MiB register port. I2C-over-AUX requests become operations on a byte-level I2C master: start with address and direction, write a byte, read a byte, and stop. When the request finishes, the block returns a 2-bit reply code and any bytes it read.

Requests with the middle-of-transaction flag leave the I2C bus open when they finish. The block records whether the bus is open, along with the 7-bit address and the command of the last such request. A follow-on request that targets the same address with the same command continues the open transfer with no new start. A change of address or command closes the transfer with a stop and opens it again with a new start. The upstream AUX decoder drives the request side. The I2C bit engine and a register fabric serve the two downstream ports.

Top module: `auxreq_seq`

## Requirements
- R1: Any command other than 0x0, 0x1, 0x4, 0x5, 0x8 or 0x9 completes with reply 01 (AUX NACK). It issues no register access and no I2C operation, and it leaves the open state, the stored address and the stored command unchanged.
- R2: A native request (0x8 write, 0x9 read) performs exactly len byte accesses on the register port, one per reg_valid/reg_ack handshake. The addresses are req_addr, req_addr+1, and so on, wrapping modulo 2^20. Write byte i is req_wdata[8i+:8].
- R3: In a native request, a reg_err on any access ends the request at once with reply 01, and no further accesses follow. If every access succeeds, the reply is 00 (ACK).
- R4: A plain I2C request (0x0 write, 0x1 read) first issues STOP if the bus is open. It then issues START with i2c_addr = req_addr[6:0] and i2c_rw = command bit 0 (1 = read). The i2c_op codes are 0 START, 1 WRITE, 2 READ and 3 STOP. A START is never issued while the bus is open.
- R5: In a plain I2C request, a NACK on START gives reply 10 (I2C NACK) and no data bytes. A NACK on a data byte ends the data phase early with reply 10. STOP is always the last operation, so the bus is closed when done is asserted.
- R6: A MOT request (0x4 write, 0x5 read) behaves according to the bus state:
  - Bus idle: it issues START.
  - Bus open, with the same 7-bit address and the same command as last stored: it issues neither STOP nor START.
  - Bus open, with a different address or command: it issues STOP and then START.
  Every MOT request then stores its own address and command.
- R7: A MOT request whose bytes all succeed replies 00 and issues no STOP, so the bus stays open. A NACK on a data byte causes a STOP and reply 10.
- R8: A MOT request whose START is NACKed issues a STOP, replies 10 and leaves the bus closed.
- R9: done is high for exactly one cycle per request. reply is valid in that same cycle, with the encoding 00 ACK, 01 AUX NACK, 10 I2C NACK.
- R10: req_ready is high only while the block is idle. A request is accepted on req_valid && req_ready, and req_ready stays low from acceptance until done.
- R11: At done, rdata[8i+:8] holds read byte i of the request. Bytes that were not read, and every byte of a write request, are zero.
- R12: len = 0 behaves as follows:
  - Native: reply 00 with no access.
  - Plain I2C: START then STOP.
  - MOT: only the start or restart decision, and no stop after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_cmd | input | 4 | Command code |
| req_addr | input | 20 | Native address, or I2C address in bits 6:0 |
| req_len | input | 5 | Byte count, 0 to 16 |
| req_wdata | input | 128 | Write bytes, byte i at bits 8i+7:8i |
| done | output | 1 | One-cycle completion pulse |
| reply | output | 2 | Reply code, valid with done |
| rdata | output | 128 | Read bytes, valid with done |
| reg_valid | output | 1 | Register access request, held until reg_ack |
| reg_write | output | 1 | 1 = write, 0 = read |
| reg_addr | output | 20 | Register byte address |
| reg_wdata | output | 8 | Register write byte |
| reg_ack | input | 1 | Register access complete |
| reg_err | input | 1 | Register access failed, qualified by reg_ack |
| reg_rdata | input | 8 | Register read byte, qualified by reg_ack |
| i2c_cmd_valid | output | 1 | I2C operation request, held until i2c_done |
| i2c_op | output | 2 | 0 START, 1 WRITE, 2 READ, 3 STOP |
| i2c_addr | output | 7 | Target address for START |
| i2c_rw | output | 1 | Direction for START, 1 = read |
| i2c_wdata | output | 8 | Byte for WRITE |
| i2c_done | input | 1 | I2C operation complete |
| i2c_nack | input | 1 | Target did not acknowledge, qualified by i2c_done |
| i2c_rdata | input | 8 | Byte from READ, qualified by i2c_done |

## Verification
The assertions check the following on every cycle:
- No START is issued while the bus is open.
- Plain I2C requests end with the bus closed, and successful MOT requests end with it open.
- Native addresses step by one between accepted accesses.
- A register error is followed at once by an AUX NACK completion.
- An unknown command produces no port activity.
- done is a single-cycle pulse, and req_ready is never high while an operation is outstanding.

The exact order of operations, the restart decision across consecutive MOT requests, the returned data bytes and the absence of side effects from a rejected command show up only in the bench scenarios. There, each operation observed on the two downstream ports is matched against a behavioural prediction.

// File: rtl/auxreq_pkg.sv
package auxreq_pkg;

  // request command codes: bit 0 = read, bit 2 = keep transfer open, bit 3 = native
  localparam logic [3:0] CMD_I2C_WR = 4'h0;
  localparam logic [3:0] CMD_I2C_RD = 4'h1;
  localparam logic [3:0] CMD_MOT_WR = 4'h4;
  localparam logic [3:0] CMD_MOT_RD = 4'h5;
  localparam logic [3:0] CMD_NAT_WR = 4'h8;
  localparam logic [3:0] CMD_NAT_RD = 4'h9;

  localparam logic [1:0] RPL_ACK      = 2'b00;
  localparam logic [1:0] RPL_AUX_NACK = 2'b01;
  localparam logic [1:0] RPL_I2C_NACK = 2'b10;

  localparam logic [1:0] OP_START = 2'd0;
  localparam logic [1:0] OP_WRITE = 2'd1;
  localparam logic [1:0] OP_READ  = 2'd2;
  localparam logic [1:0] OP_STOP  = 2'd3;

  typedef enum logic [2:0] {
    S_IDLE, S_DISPATCH, S_REG, S_PRESTOP, S_START, S_XFER, S_ENDSTOP, S_DONE
  } seq_state_e;

  function automatic logic is_native(input logic [3:0] c);
    return (c == CMD_NAT_WR) || (c == CMD_NAT_RD);
  endfunction

  function automatic logic is_plain_i2c(input logic [3:0] c);
    return (c == CMD_I2C_WR) || (c == CMD_I2C_RD);
  endfunction

  function automatic logic is_mot_i2c(input logic [3:0] c);
    return (c == CMD_MOT_WR) || (c == CMD_MOT_RD);
  endfunction

  function automatic logic is_known(input logic [3:0] c);
    return is_native(c) || is_plain_i2c(c) || is_mot_i2c(c);
  endfunction

endpackage

// File: rtl/auxreq_mot_track.sv
module auxreq_mot_track #(
  parameter int I2C_AW = 7,
  parameter int CMD_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              store,
  input  logic [I2C_AW-1:0] cur_addr,
  input  logic [CMD_W-1:0]  cur_cmd,
  input  logic              set_open,
  input  logic              clr_open,
  output logic              bus_open,
  output logic              need_restart
);

  logic [I2C_AW-1:0] last_addr_q;
  logic [CMD_W-1:0]  last_cmd_q;
  logic              open_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q      <= 1'b0;
      last_addr_q <= '0;
      last_cmd_q  <= '0;
    end else begin
      if (store) begin
        last_addr_q <= cur_addr;
        last_cmd_q  <= cur_cmd;
      end
      if (clr_open)      open_q <= 1'b0;
      else if (set_open) open_q <= 1'b1;
    end
  end

  assign bus_open     = open_q;
  assign need_restart = open_q && ((cur_addr != last_addr_q) || (cur_cmd != last_cmd_q));

  // R8/R5: closing and opening never requested together
  a_r8_open_close_excl: assert property (@(posedge clk) disable iff (rst)
    !(set_open && clr_open));

endmodule

// File: rtl/auxreq_byte_buf.sv
module auxreq_byte_buf #(
  parameter int MAX_LEN = 16,
  parameter int IDX_W   = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic [MAX_LEN*8-1:0] wdata_in,
  input  logic                 cap_en,
  input  logic [IDX_W-1:0]     cap_idx,
  input  logic [7:0]           cap_byte,
  input  logic [IDX_W-1:0]     sel_idx,
  output logic [7:0]           tx_byte,
  output logic [MAX_LEN*8-1:0] rdata_out
);

  logic [MAX_LEN*8-1:0] tx_vec;

  always_ff @(posedge clk) begin
    if (rst)       tx_vec <= '0;
    else if (load) tx_vec <= wdata_in;
  end

  assign tx_byte = tx_vec[{sel_idx, 3'b000} +: 8];

  for (genvar g = 0; g < MAX_LEN; g++) begin : g_rx
    logic [7:0] rx_q;
    always_ff @(posedge clk) begin
      if (rst || load)                          rx_q <= '0;
      else if (cap_en && cap_idx == IDX_W'(g))  rx_q <= cap_byte;
    end
    assign rdata_out[g*8 +: 8] = rx_q;
  end

endmodule

// File: rtl/auxreq_seq.sv
module auxreq_seq
  import auxreq_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int MAX_LEN = 16,
  parameter int I2C_AW  = 7,
  localparam int LEN_W  = $clog2(MAX_LEN + 1),
  localparam int IDX_W  = $clog2(MAX_LEN),
  localparam int DATA_W = MAX_LEN * 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [3:0]        req_cmd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              done,
  output logic [1:0]        reply,
  output logic [DATA_W-1:0] rdata,
  output logic              reg_valid,
  output logic              reg_write,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [7:0]        reg_wdata,
  input  logic              reg_ack,
  input  logic              reg_err,
  input  logic [7:0]        reg_rdata,
  output logic              i2c_cmd_valid,
  output logic [1:0]        i2c_op,
  output logic [I2C_AW-1:0] i2c_addr,
  output logic              i2c_rw,
  output logic [7:0]        i2c_wdata,
  input  logic              i2c_done,
  input  logic              i2c_nack,
  input  logic [7:0]        i2c_rdata
);

  seq_state_e        state_q;
  logic [3:0]        cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;
  logic [IDX_W-1:0]  idx_q;
  logic [1:0]        reply_q;

  logic accept, last_byte, plain_q, mot_q, nat_q;
  logic bus_open, need_restart, trk_store, trk_set, trk_clr;
  logic cap_en;
  logic [7:0] cap_byte, tx_byte;

  assign accept    = req_valid && (state_q == S_IDLE);
  assign last_byte = (LEN_W'(idx_q) + LEN_W'(1)) == len_q;
  assign plain_q   = is_plain_i2c(cmd_q);
  assign mot_q     = is_mot_i2c(cmd_q);
  assign nat_q     = is_native(cmd_q);

  auxreq_mot_track #(.I2C_AW(I2C_AW), .CMD_W(4)) u_track (
    .clk(clk), .rst(rst), .store(trk_store), .cur_addr(addr_q[I2C_AW-1:0]),
    .cur_cmd(cmd_q), .set_open(trk_set), .clr_open(trk_clr),
    .bus_open(bus_open), .need_restart(need_restart)
  );

  assign trk_store = (state_q == S_DISPATCH) && mot_q;
  assign trk_set   = (state_q == S_START) && i2c_done && !i2c_nack;
  assign trk_clr   = ((state_q == S_PRESTOP) || (state_q == S_ENDSTOP)) && i2c_done;

  assign cap_en   = ((state_q == S_REG) && reg_ack && !reg_err && !reg_write) ||
                    ((state_q == S_XFER) && i2c_done && !i2c_nack && cmd_q[0]);
  assign cap_byte = (state_q == S_REG) ? reg_rdata : i2c_rdata;

  auxreq_byte_buf #(.MAX_LEN(MAX_LEN), .IDX_W(IDX_W)) u_buf (
    .clk(clk), .rst(rst), .load(accept), .wdata_in(req_wdata),
    .cap_en(cap_en), .cap_idx(idx_q), .cap_byte(cap_byte),
    .sel_idx(idx_q), .tx_byte(tx_byte), .rdata_out(rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      cmd_q   <= '0;
      addr_q  <= '0;
      len_q   <= '0;
      idx_q   <= '0;
      reply_q <= RPL_ACK;
    end else begin
      unique case (state_q)
        S_IDLE: if (accept) begin
          cmd_q   <= req_cmd;
          addr_q  <= req_addr;
          len_q   <= req_len;
          idx_q   <= '0;
          state_q <= S_DISPATCH;
        end
        S_DISPATCH: begin
          reply_q <= RPL_ACK;
          if (nat_q)
            state_q <= (len_q == '0) ? S_DONE : S_REG;
          else if (plain_q)
            state_q <= bus_open ? S_PRESTOP : S_START;
          else if (mot_q) begin
            if (!bus_open)         state_q <= S_START;
            else if (need_restart) state_q <= S_PRESTOP;
            else                   state_q <= (len_q == '0) ? S_DONE : S_XFER;
          end else begin
            reply_q <= RPL_AUX_NACK;
            state_q <= S_DONE;
          end
        end
        S_REG: if (reg_ack) begin
          if (reg_err) begin
            reply_q <= RPL_AUX_NACK;
            state_q <= S_DONE;
          end else if (last_byte) state_q <= S_DONE;
          else idx_q <= idx_q + IDX_W'(1);
        end
        S_PRESTOP: if (i2c_done) state_q <= S_START;
        S_START: if (i2c_done) begin
          if (i2c_nack) begin
            reply_q <= RPL_I2C_NACK;
            state_q <= S_ENDSTOP;
          end else if (len_q == '0) state_q <= plain_q ? S_ENDSTOP : S_DONE;
          else state_q <= S_XFER;
        end
        S_XFER: if (i2c_done) begin
          if (i2c_nack) begin
            reply_q <= RPL_I2C_NACK;
            state_q <= S_ENDSTOP;
          end else if (last_byte) state_q <= plain_q ? S_ENDSTOP : S_DONE;
          else idx_q <= idx_q + IDX_W'(1);
        end
        S_ENDSTOP: if (i2c_done) state_q <= S_DONE;
        S_DONE:    state_q <= S_IDLE;
        default:   state_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready     = (state_q == S_IDLE);
  assign done          = (state_q == S_DONE);
  assign reply         = reply_q;
  assign reg_valid     = (state_q == S_REG);
  assign reg_write     = (cmd_q == CMD_NAT_WR);
  assign reg_addr      = addr_q + ADDR_W'(idx_q);
  assign reg_wdata     = tx_byte;
  assign i2c_cmd_valid = (state_q == S_PRESTOP) || (state_q == S_START) ||
                         (state_q == S_XFER) || (state_q == S_ENDSTOP);
  assign i2c_op        = (state_q == S_START) ? OP_START :
                         (state_q == S_XFER)  ? (cmd_q[0] ? OP_READ : OP_WRITE) : OP_STOP;
  assign i2c_addr      = addr_q[I2C_AW-1:0];
  assign i2c_rw        = cmd_q[0];
  assign i2c_wdata     = tx_byte;

  // R10: nothing outstanding downstream while the block offers ready
  a_r10_ready_idle: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!reg_valid && !i2c_cmd_valid && !done));

  // R9: completion is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R2: consecutive native accesses step the address by one
  a_r2_addr_step: assert property (@(posedge clk) disable iff (rst)
    (reg_valid && reg_ack && !reg_err) |=>
      (!reg_valid || reg_addr == ($past(reg_addr) + ADDR_W'(1))));

  // R3: a failed register access finishes the request at once with AUX NACK
  a_r3_err_stops: assert property (@(posedge clk) disable iff (rst)
    (reg_valid && reg_ack && reg_err) |=> (done && reply == RPL_AUX_NACK));

  // R1: unknown command causes no downstream activity and an AUX NACK
  a_r1_bad_quiet: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !is_known(req_cmd)) |=> (!reg_valid && !i2c_cmd_valid));
  a_r1_bad_reply: assert property (@(posedge clk) disable iff (rst)
    $past(req_valid && req_ready && !is_known(req_cmd), 2) |-> (done && reply == RPL_AUX_NACK));

  // R4: a start never goes out on an open bus
  a_r4_start_closed: assert property (@(posedge clk) disable iff (rst)
    (i2c_cmd_valid && i2c_op == OP_START) |-> !bus_open);

  // R5: plain I2C requests always complete with the bus closed
  a_r5_plain_closed: assert property (@(posedge clk) disable iff (rst)
    (done && plain_q) |-> !bus_open);

  // R7: a successful MOT request leaves the bus open
  a_r7_mot_open: assert property (@(posedge clk) disable iff (rst)
    (done && mot_q && reply == RPL_ACK) |-> bus_open);

endmodule

// File: tb/auxreq_seq_tb_top.sv
`timescale 1ns/1ps
module auxreq_seq_tb_top;
  localparam int ADDR_W = 20, MAX_LEN = 16, I2C_AW = 7, DW = MAX_LEN * 8;
  localparam logic [6:0] DEV = 7'h50;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_ready;
  logic [3:0] req_cmd = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [4:0] req_len = '0;
  logic [DW-1:0] req_wdata = '0;
  logic done; logic [1:0] reply; logic [DW-1:0] rdata;
  logic reg_valid, reg_write; logic [ADDR_W-1:0] reg_addr; logic [7:0] reg_wdata;
  logic reg_ack = 1'b0, reg_err = 1'b0; logic [7:0] reg_rdata = '0;
  logic i2c_cmd_valid; logic [1:0] i2c_op; logic [6:0] i2c_addr; logic i2c_rw;
  logic [7:0] i2c_wdata;
  logic i2c_done = 1'b0, i2c_nack = 1'b0; logic [7:0] i2c_rdata = '0;

  always #2.5 clk = ~clk;

  auxreq_seq dut_i (.*);

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  string cur_req = "R0";
  logic [31:0] exp_q[$];
  bit [7:0] dev_mem [int];
  bit [7:0] shadow [int];
  int fail_addr = -1, nack_idx = -1, resp_bytes = 0;
  bit [7:0] rd_ctr = 0, p_rd_ctr = 0;
  bit m_open = 0; bit [6:0] m_la = 0; bit [3:0] m_lc = 0;
  logic [1:0] exp_reply; logic [DW-1:0] exp_rdata;
  int ra; bit rerr;

  task automatic check(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic see_op(logic [31:0] op);
    logic [31:0] e;
    if (exp_q.size() == 0) check(0, cur_req, "unexpected downstream op", op, 0);
    else begin
      e = exp_q.pop_front();
      check(op == e, cur_req, "downstream op", op, e);
    end
  endtask

  // register port responder: kind 1 write, 2 read, {kind, addr, data}
  always @(negedge clk) begin
    if (reg_ack) begin reg_ack = 0; reg_err = 0; end
    else if (reg_valid) begin
      ra = int'(reg_addr); rerr = (ra == fail_addr);
      reg_ack = 1; reg_err = rerr; reg_rdata = 0;
      if (reg_write) begin
        if (!rerr) dev_mem[ra] = reg_wdata;
        see_op({4'd1, reg_addr, reg_wdata});
      end else begin
        if (!rerr && dev_mem.exists(ra)) reg_rdata = dev_mem[ra];
        see_op({4'd2, reg_addr, reg_rdata});
      end
    end
  end

  // I2C master responder: kind 3 start, 4 write, 5 read, 6 stop
  always @(negedge clk) begin
    if (i2c_done) begin i2c_done = 0; i2c_nack = 0; end
    else if (i2c_cmd_valid) begin
      i2c_done = 1; i2c_nack = 0; i2c_rdata = 0;
      case (i2c_op)
        2'd0: begin i2c_nack = (i2c_addr != DEV); see_op({4'd3, 20'd0, i2c_addr, i2c_rw}); end
        2'd1: begin i2c_nack = (resp_bytes == nack_idx); resp_bytes++; see_op({4'd4, 20'd0, i2c_wdata}); end
        2'd2: begin
          if (resp_bytes == nack_idx) i2c_nack = 1;
          else begin i2c_rdata = 8'hC0 + rd_ctr; rd_ctr++; end
          resp_bytes++;
          see_op({4'd5, 20'd0, i2c_rdata});
        end
        default: see_op({4'd6, 28'd0});
      endcase
    end
  end

  function automatic logic [31:0] byte_op(bit rd, logic [7:0] d);
    return {rd ? 4'd5 : 4'd4, 20'd0, d};
  endfunction

  // behavioural prediction of ops, reply and read data
  task automatic predict(logic [3:0] c, logic [19:0] a, int len, logic [DW-1:0] wd);
    logic [6:0] a7 = a[6:0];
    bit st;
    logic [7:0] d;
    exp_rdata = '0; exp_reply = 2'b00;
    if (c == 4'h8 || c == 4'h9) begin
      for (int i = 0; i < len; i++) begin
        int aa = int'(20'(a + 20'(i)));
        bit er = (aa == fail_addr);
        if (c == 4'h8) begin
          exp_q.push_back({4'd1, 20'(aa), wd[8*i +: 8]});
          if (!er) shadow[aa] = wd[8*i +: 8];
        end else begin
          d = (!er && shadow.exists(aa)) ? shadow[aa] : 8'h00;
          exp_q.push_back({4'd2, 20'(aa), d});
          if (!er) exp_rdata[8*i +: 8] = d;
        end
        if (er) begin exp_reply = 2'b01; return; end
      end
    end else if (c == 4'h0 || c == 4'h1 || c == 4'h4 || c == 4'h5) begin
      st = 0;
      if (c[2] == 1'b0) begin
        if (m_open) begin exp_q.push_back({4'd6, 28'd0}); m_open = 0; end
        st = 1;
      end else begin
        if (!m_open) st = 1;
        else if (a7 != m_la || c != m_lc) begin exp_q.push_back({4'd6, 28'd0}); m_open = 0; st = 1; end
        m_la = a7; m_lc = c;
      end
      if (st) begin
        exp_q.push_back({4'd3, 20'd0, a7, c[0]});
        if (a7 != DEV) begin exp_q.push_back({4'd6, 28'd0}); exp_reply = 2'b10; return; end
        m_open = 1;
      end
      for (int i = 0; i < len; i++) begin
        if (i == nack_idx) begin
          exp_q.push_back(byte_op(c[0], c[0] ? 8'h00 : wd[8*i +: 8]));
          exp_q.push_back({4'd6, 28'd0}); m_open = 0; exp_reply = 2'b10; return;
        end
        if (c[0]) begin
          d = 8'hC0 + p_rd_ctr; p_rd_ctr++;
          exp_rdata[8*i +: 8] = d;
          exp_q.push_back(byte_op(1, d));
        end else exp_q.push_back(byte_op(0, wd[8*i +: 8]));
      end
      if (c[2] == 1'b0) begin exp_q.push_back({4'd6, 28'd0}); m_open = 0; end
    end else exp_reply = 2'b01;
  endtask

  task automatic run(string tag, logic [3:0] c, logic [19:0] a, int len, logic [DW-1:0] wd);
    bit busy_ok = 1;
    cur_req = tag; resp_bytes = 0;
    exp_q.delete();
    predict(c, a, len, wd);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_cmd = c; req_addr = a; req_len = 5'(len); req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    while (!done) begin
      if (req_ready) busy_ok = 0;
      @(negedge clk);
    end
    check(busy_ok, "R10", {tag, " ready low while busy"}, 0, 0);
    check(reply == exp_reply, "R9", {tag, " reply"}, reply, exp_reply);
    check(rdata == exp_rdata, "R11", {tag, " rdata"}, rdata, exp_rdata);
    check(exp_q.size() == 0, tag, "missing downstream ops", exp_q.size(), 0);
    @(negedge clk);
    check(!done, "R9", {tag, " done pulse width"}, done, 0);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete, actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(req_ready && !done && !reg_valid && !i2c_cmd_valid, "R10", "reset state",
          {req_ready, done, reg_valid, i2c_cmd_valid}, 4'b1000);

    run("R2 native write", 4'h8, 20'h00010, 4, 128'h0000_0000_0000_0000_0000_0000_4433_2211);
    run("R11 native read", 4'h9, 20'h00010, 4, '0);
    run("R2 native wrap write", 4'h8, 20'hFFFFE, 3, 128'h77_6655);
    run("R2 native wrap read", 4'h9, 20'hFFFFE, 3, '0);
    fail_addr = 32'h12;
    run("R3 native read error", 4'h9, 20'h00010, 4, '0);
    fail_addr = -1;
    run("R12 native len0", 4'h9, 20'h00010, 0, '0);
    run("R1 bad cmd 3", 4'h3, 20'h00050, 2, '0);
    run("R1 bad cmd F", 4'hF, 20'h00010, 2, '0);
    run("R5 plain write", 4'h0, 20'h00050, 2, 128'hBBAA);
    run("R5 plain read addr nack", 4'h1, 20'h00033, 2, '0);
    nack_idx = 1;
    run("R5 plain read data nack", 4'h1, 20'h00050, 3, '0);
    nack_idx = -1;
    run("R6 mot write open", 4'h4, 20'h00050, 2, 128'h2211);
    run("R6 mot write continue", 4'h4, 20'h00050, 1, 128'h33);
    run("R1 bad cmd on open bus", 4'h7, 20'h00050, 1, '0);
    run("R12 mot len0 continue", 4'h4, 20'h00050, 0, '0);
    run("R7 mot continue after reject", 4'h4, 20'h00050, 1, 128'h44);
    run("R6 mot restart on cmd", 4'h5, 20'h00050, 2, '0);
    run("R8 mot restart bad addr", 4'h5, 20'h00051, 1, '0);
    run("R6 mot start from idle", 4'h5, 20'h00050, 2, '0);
    run("R4 plain on open bus", 4'h0, 20'h00050, 1, 128'h99);
    run("R12 plain len0", 4'h1, 20'h00050, 0, '0);
    run("R6 mot open again", 4'h4, 20'h00050, 1, 128'h10);
    nack_idx = 1;
    run("R7 mot data nack", 4'h4, 20'h00050, 3, 128'h30_2010);
    nack_idx = -1;
    run("R12 mot len0 from idle", 4'h5, 20'h00050, 0, '0);
    run("R6 mot restart on addr", 4'h5, 20'h00052, 1, '0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule